// File: doc/BRIEF.md
# Masked Interrupt Controller with Global Enable

The block collects three interrupt sources for a small sequencer-driven core: an edge on a dedicated external pin (rising or falling, chosen by software), a mismatch between a group of port input pins and the value captured at the most recent port read, and a one-cycle overflow pulse from a timer. Each source owns a sticky flag and an enable bit. A single global enable gates every request.

Requests are accepted only on an instruction-cycle boundary marked by the sequencer. When a request is accepted, the block signals the sequencer to save the return address and to jump to the fixed interrupt vector. In the same step it drops the global enable, so no further request is taken. A return strobe raises the global enable again. Flags are never cleared by hardware. A flag that software leaves set is taken again at the first boundary after the return.

All controls sit in one 8-bit register that software can read and write. Asynchronous pins pass through a two-stage synchronizer before any detection.

Top module: `irq_ctl`

## Requirements
- R1: After synchronous reset the control register reads 0x00, `vec_take` and `push_ret` are low, and `port_val` is 0.
- R2: Register bit 2 (external flag) is set when the synchronized external pin shows an edge of the polarity chosen by bit 6 (1 = rising, 0 = falling). An edge of the other polarity leaves it unchanged. The flag is visible three clocks after the pin changes.
- R3: Register bit 1 (port flag) is set on every clock in which the synchronized port pins differ from the copy captured by the last `port_rd` strobe. Each `port_rd` reloads that copy from `port_val`.
- R4: A `tmr_ovf` pulse sets register bit 0 (timer flag) on the next clock.
- R5: Flags are sticky. Only a register write changes them to the written value, and an event arriving in the same clock as a clearing write still leaves its flag set.
- R6: When `cycle_end` is high, the global enable is set, and at least one flag has its enable set, the next clock raises `vec_take` and `push_ret` for one cycle with `vec_addr` = 0x004. When no enabled flag is set, nothing is taken. Enables are bit 5 (external), bit 4 (port) and bit 3 (timer).
- R7: Accepting a request clears the global enable (bit 7). While it is low, no request is taken and flags stay pending.
- R8: A `retfie` strobe sets the global enable, and a flag still pending is taken again at the next boundary.
- R9: A register write loads all eight bits as laid out in R2 to R7 (gie, edge select, three enables, three flags), and `reg_rdata` shows the register at all times.
- R10: For the global enable, acceptance has priority over `retfie`, and `retfie` has priority over a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 4 | Asynchronous port input pins |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| port_rd | input | 1 | Port read strobe; reloads the comparison copy |
| cycle_end | input | 1 | Instruction-cycle boundary marker |
| retfie | input | 1 | Return-from-interrupt strobe |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| port_val | output | 4 | Synchronized port pin value |
| vec_take | output | 1 | Request accepted, jump to vector |
| push_ret | output | 1 | Save the return address |
| vec_addr | output | 13 | Vector address while `vec_take` is high, else 0 |

## Verification
The assertions assume that `tmr_ovf` arrives already synchronous. They also assume that the pins are low during reset, so that the first synchronized sample produces no false edge. The stimulus holds every pin and strobe low while reset is applied and changes inputs only at the falling clock edge. Random phases mix boundaries, returns, writes and pin activity in the same cycles, so that the priority rules of R5 and R10 are exercised against the reference model.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int CTL_W = 8;

    typedef struct packed {
        logic ext;
        logic port;
        logic tmr;
    } src_t;

    // field order is the software-visible bit layout, msb first
    typedef struct packed {
        logic gie;
        logic rise;
        src_t en;
        src_t flag;
    } ctl_t;

    function automatic logic any_pending(input ctl_t c);
        return |(c.en & c.flag);
    endfunction

    function automatic logic edge_hit(input logic rise, input logic now, input logic prev);
        return rise ? (now & ~prev) : (~now & prev);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_ctl_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_s,
    input  logic [NPORT-1:0] port_s,
    input  logic             tmr_ovf,
    input  logic             rise,
    input  logic             port_rd,
    output src_t             ev
);
    logic             ext_prev;
    logic [NPORT-1:0] port_copy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev  <= 1'b0;
            port_copy <= '0;
        end else begin
            ext_prev <= ext_s;
            if (port_rd) port_copy <= port_s;
        end
    end

    always_comb begin
        ev.ext  = edge_hit(rise, ext_s, ext_prev);
        ev.port = |(port_s ^ port_copy);
        ev.tmr  = tmr_ovf;
    end
endmodule

// File: rtl/irq_core.sv
module irq_core
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  src_t             ev,
    input  logic             cycle_end,
    input  logic             retfie,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output ctl_t             ctl_q,
    output logic             take_q
);
    ctl_t ctl_d;
    logic take;

    always_comb begin
        take  = cycle_end & ctl_q.gie & any_pending(ctl_q);
        ctl_d = ctl_q;
        if (reg_wr) ctl_d = ctl_t'(reg_wdata);
        ctl_d.flag = src_t'(ctl_d.flag | ev);
        if (retfie) ctl_d.gie = 1'b1;
        if (take)   ctl_d.gie = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            take_q <= 1'b0;
        end else begin
            ctl_q  <= ctl_d;
            take_q <= take;
        end
    end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int          NPORT = 4,
    parameter int          PC_W  = 13,
    parameter logic [12:0] VEC   = 13'h004
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic [NPORT-1:0] port_pins,
    input  logic             tmr_ovf,
    input  logic             port_rd,
    input  logic             cycle_end,
    input  logic             retfie,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    output logic [NPORT-1:0] port_val,
    output logic             vec_take,
    output logic             push_ret,
    output logic [PC_W-1:0]  vec_addr
);
    localparam int SYNC_W = NPORT + 1;

    logic [SYNC_W-1:0] raw, synced;
    src_t ev;
    ctl_t ctl;
    logic take_q;

    assign raw = {ext_pin, port_pins};

    irq_sync #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(synced)
    );

    irq_detect #(.NPORT(NPORT)) u_detect (
        .clk(clk), .rst(rst),
        .ext_s(synced[SYNC_W-1]), .port_s(synced[NPORT-1:0]),
        .tmr_ovf(tmr_ovf), .rise(ctl.rise), .port_rd(port_rd), .ev(ev)
    );

    irq_core u_core (
        .clk(clk), .rst(rst), .ev(ev), .cycle_end(cycle_end), .retfie(retfie),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .ctl_q(ctl), .take_q(take_q)
    );

    assign reg_rdata = ctl;
    assign port_val  = synced[NPORT-1:0];
    assign vec_take  = take_q;
    assign push_ret  = take_q;
    assign vec_addr  = take_q ? PC_W'(VEC) : '0;
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        tmr_ovf,
    input logic        cycle_end,
    input logic        retfie,
    input logic        reg_wr,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  reg_rdata,
    input logic        vec_take,
    input logic        push_ret,
    input logic [12:0] vec_addr
);
    a_r7_take_clears_gie: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> !reg_rdata[7]);

    a_r6_take_needs_cause: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> ($past(cycle_end) && $past(reg_rdata[7]) &&
                      (($past(reg_rdata[5:3]) & $past(reg_rdata[2:0])) != 3'b000)));

    a_r6_vector_and_push: assert property (@(posedge clk) disable iff (rst)
        vec_take |-> (push_ret && vec_addr == 13'h004));

    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr) |-> (($past(reg_rdata[2:0]) & ~reg_rdata[2:0]) == 3'b000));

    a_r4_timer_sets_flag: assert property (@(posedge clk) disable iff (rst)
        $past(tmr_ovf) |-> reg_rdata[0]);

    a_r8_return_sets_gie: assert property (@(posedge clk) disable iff (rst)
        ($past(retfie) && !vec_take) |-> reg_rdata[7]);

    a_r10_write_lowest: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_wr) && !$past(retfie) && !vec_take) |-> (reg_rdata[7] == $past(reg_wdata[7])));
endmodule

bind irq_ctl irq_ctl_chk u_chk (
    .clk(clk), .rst(rst), .tmr_ovf(tmr_ovf), .cycle_end(cycle_end), .retfie(retfie),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_take(vec_take), .push_ret(push_ret), .vec_addr(vec_addr)
);

// File: tb/irq_ctl_bench.sv
module irq_ctl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_pin = 1'b0;
    logic [3:0]  port_pins = '0;
    logic        tmr_ovf = 1'b0, port_rd = 1'b0, cycle_end = 1'b0, retfie = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [3:0]  port_val;
    logic        vec_take, push_ret;
    logic [12:0] vec_addr;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    irq_ctl u_irq_ctl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .port_pins(port_pins), .tmr_ovf(tmr_ovf),
        .port_rd(port_rd), .cycle_end(cycle_end), .retfie(retfie), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_val(port_val),
        .vec_take(vec_take), .push_ret(push_ret), .vec_addr(vec_addr)
    );

    // behavioural reference state
    logic [7:0] m_reg;
    logic [1:0] m_ext;
    logic [3:0] m_p1, m_p2, m_copy;
    logic       m_prev, m_take;

    always @(posedge clk) begin
        logic ev_e, ev_p, acc;
        logic [7:0] nr;
        if (rst) begin
            m_reg = 0; m_ext = 0; m_p1 = 0; m_p2 = 0; m_copy = 0; m_prev = 0; m_take = 0;
        end else begin
            ev_e = m_reg[6] ? (m_ext[1] && !m_prev) : (!m_ext[1] && m_prev);
            ev_p = (m_p2 != m_copy);
            acc  = cycle_end && m_reg[7] && ((m_reg[5:3] & m_reg[2:0]) != 0);
            nr   = reg_wr ? reg_wdata : m_reg;
            nr[2] = nr[2] | ev_e;
            nr[1] = nr[1] | ev_p;
            nr[0] = nr[0] | tmr_ovf;
            if (retfie) nr[7] = 1'b1;
            if (acc)    nr[7] = 1'b0;
            if (port_rd) m_copy = m_p2;
            m_prev = m_ext[1];
            m_ext  = {m_ext[0], ext_pin};
            m_p2   = m_p1;
            m_p1   = port_pins;
            m_reg  = nr;
            m_take = acc;
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            cmp("R9 enables/select", {24'd0, reg_rdata[6:3]}, {24'd0, m_reg[6:3]});
            cmp("R7 gie", {31'd0, reg_rdata[7]}, {31'd0, m_reg[7]});
            cmp("R2 ext flag", {31'd0, reg_rdata[2]}, {31'd0, m_reg[2]});
            cmp("R3 port flag", {31'd0, reg_rdata[1]}, {31'd0, m_reg[1]});
            cmp("R4 timer flag", {31'd0, reg_rdata[0]}, {31'd0, m_reg[0]});
            cmp("R3 port_val", {28'd0, port_val}, {28'd0, m_p2});
            cmp("R6 vec_take", {31'd0, vec_take}, {31'd0, m_take});
            cmp("R6 push_ret", {31'd0, push_ret}, {31'd0, m_take});
            cmp("R6 vec_addr", {19'd0, vec_addr}, m_take ? 32'h4 : 32'h0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v; step(1); reg_wr = 1'b0;
    endtask

    task automatic pulse_end();
        cycle_end = 1'b1; step(1); cycle_end = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        cmp("R1 reset reg", {24'd0, reg_rdata}, 32'h00);
        cmp("R1 reset take", {31'd0, vec_take}, 32'h0);
        cmp("R1 reset port", {28'd0, port_val}, 32'h0);

        wr(8'hF8);
        cmp("R9 write all", {24'd0, reg_rdata}, 32'hF8);

        ext_pin = 1'b1; step(4);
        cmp("R2 rising edge flag", {31'd0, reg_rdata[2]}, 32'h1);
        pulse_end();
        cmp("R6 take", {31'd0, vec_take}, 32'h1);
        cmp("R6 vector", {19'd0, vec_addr}, 32'h4);
        cmp("R7 gie cleared", {31'd0, reg_rdata[7]}, 32'h0);
        pulse_end();
        cmp("R7 no take while gie low", {31'd0, vec_take}, 32'h0);
        cmp("R5 flag still pending", {31'd0, reg_rdata[2]}, 32'h1);
        retfie = 1'b1; step(1); retfie = 1'b0;
        cmp("R8 gie restored", {31'd0, reg_rdata[7]}, 32'h1);
        pulse_end();
        cmp("R8 retrigger", {31'd0, vec_take}, 32'h1);

        wr(8'h38); step(3);
        cmp("R2 wrong polarity ignored", {31'd0, reg_rdata[2]}, 32'h0);
        ext_pin = 1'b0; step(4);
        cmp("R2 falling edge flag", {31'd0, reg_rdata[2]}, 32'h1);

        wr(8'h38);
        tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
        cmp("R4 timer flag", {31'd0, reg_rdata[0]}, 32'h1);
        tmr_ovf = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h38; step(1);
        tmr_ovf = 1'b0; reg_wr = 1'b0;
        cmp("R5 event beats clear", {31'd0, reg_rdata[0]}, 32'h1);

        wr(8'h38);
        port_rd = 1'b1; step(1); port_rd = 1'b0;
        port_pins = 4'b0101; step(4);
        cmp("R3 port mismatch flag", {31'd0, reg_rdata[1]}, 32'h1);
        cmp("R3 port value", {28'd0, port_val}, 32'h5);
        wr(8'h38);
        cmp("R3 mismatch re-sets", {31'd0, reg_rdata[1]}, 32'h1);
        port_rd = 1'b1; step(1); port_rd = 1'b0;
        wr(8'h38); step(1);
        cmp("R3 copy reloaded", {31'd0, reg_rdata[1]}, 32'h0);

        wr(8'h81);
        pulse_end();
        cmp("R6 disabled source not taken", {31'd0, vec_take}, 32'h0);
        cmp("R6 gie kept", {31'd0, reg_rdata[7]}, 32'h1);

        wr(8'h00);
        retfie = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00; step(1);
        retfie = 1'b0; reg_wr = 1'b0;
        cmp("R10 return beats write", {31'd0, reg_rdata[7]}, 32'h1);
        wr(8'h89);
        cycle_end = 1'b1; retfie = 1'b1; step(1);
        cycle_end = 1'b0; retfie = 1'b0;
        cmp("R10 take beats return", {31'd0, vec_take}, 32'h1);
        cmp("R10 gie low", {31'd0, reg_rdata[7]}, 32'h0);

        for (int i = 0; i < 1500; i++) begin
            ext_pin   = ($urandom_range(0, 9) == 0) ? ~ext_pin : ext_pin;
            port_pins = ($urandom_range(0, 11) == 0) ? 4'($urandom) : port_pins;
            port_rd   = ($urandom_range(0, 7) == 0);
            tmr_ovf   = ($urandom_range(0, 15) == 0);
            cycle_end = (i % 4 == 3);
            retfie    = ($urandom_range(0, 9) == 0);
            reg_wr    = ($urandom_range(0, 11) == 0);
            reg_wdata = 8'($urandom);
            step(1);
        end
        {port_rd, tmr_ovf, cycle_end, retfie, reg_wr} = '0;
        step(2);
        summary();
        $finish;
    end
endmodule